// File: doc/BRIEF.md
# Two-Channel Request-Driven DMA Engine

This block moves data between memory and I/O space on behalf of two independent channels that share one bus. Each channel holds a 20-bit source address, a 20-bit destination address, a transfer counter and a 12-bit control word. Software loads these through a small register port, then arms the channel by writing the control word. An armed channel waits for its external request line. Every transfer reads one unit from the source, writes it to the destination, steps both addresses and decrements the counter.

When the counter reaches zero the channel disarms and, if asked to, pulses its interrupt line. A stop command disarms a channel at any point. The addresses and count stay readable, so the channel can be rearmed later to resume. A grant input from an outside arbiter stalls bus accesses while the bus is lent to another master. When both channels want the bus, a per-channel priority bit selects the winner.

Top module: `dma_two_ch`

## Requirements
- R1: After reset every register of both channels reads zero, both channels are disarmed, and `bus_req_o`, `bus_en_o` and `irq_o` are low.
- R2: Writing the control word (select 3) arms the channel only when control bit 4 is 1, bits 1 and 2 are not both 1, and the counter is non-zero. Otherwise the word is stored but the channel stays disarmed. Status readback (select 3) returns the enable flag in bit 12 above the control word in bits 11..0.
- R3: An armed channel is idle until its `drq_i` bit is high. Each transfer is one bus read at the source address followed by one bus write at the destination address. The write carries the read data, with the upper byte cleared for byte transfers.
- R4: After each transfer the source address steps by +1 with control bit 5 or by -1 with bit 6, and the destination address does the same with bits 8 and 9. Both bits set or both clear hold the address. The step is 2 instead of 1 when bit 11 (word) is set. Addresses wrap modulo 2^20. `bus_word_o` follows bit 11.
- R5: `bus_mem_o` is control bit 7 during the read and control bit 10 during the write (1 = memory, 0 = I/O).
- R6: The counter drops by one per completed transfer. The transfer that takes it to zero disarms the channel, and if control bit 3 is set `irq_o` for that channel pulses for exactly one cycle.
- R7: With bit 1 or bit 2 set (synchronized), each transfer starts only while `drq_i` is high. With both clear, one request starts a run that continues to zero without further requests.
- R8: When both channels are eligible, the channel with its control bit 0 set wins if exactly one has it. Otherwise the winner alternates with the channel served last.
- R9: A write to select 4 disarms the channel. Any register write to the channel whose transfer is in flight abandons that transfer, leaving addresses and count unchanged. Rearming resumes from the stored values.
- R10: While `bus_gnt_i` is low the pending access holds its address and direction, and no access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_ch_i | input | 1 | Channel addressed by the register port |
| reg_sel_i | input | 3 | 0 source, 1 destination, 2 count, 3 control/status, 4 stop |
| reg_wdata_i | input | 20 | Register write data |
| reg_rdata_o | output | 20 | Readback of the selected register |
| drq_i | input | 2 | Per-channel transfer request |
| bus_req_o | output | 1 | Bus wanted |
| bus_gnt_i | input | 1 | Bus granted; an access completes in a cycle with grant high |
| bus_en_o | output | 1 | Access pending |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_mem_o | output | 1 | 1 memory space, 0 I/O space |
| bus_word_o | output | 1 | 1 word, 0 byte |
| bus_addr_o | output | 20 | Access address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, sampled in a granted read cycle |
| irq_o | output | 2 | Per-channel end-of-run pulse |

## Verification
The bench builds the block with its default widths: 20-bit addresses, a 16-bit counter and 16-bit data. The full address width makes a decrement through zero to 0xFFFFE reachable in a single transfer. The counter width lets resumed runs keep their remaining count across a stop. The 16-bit data path tells word writes apart from byte writes by the cleared upper byte.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned NCH    = 2;
  localparam int unsigned CTRL_W = 12;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_STOP = 3'd4;

  // control word bit positions
  localparam int unsigned B_PRIO  = 0;
  localparam int unsigned B_SSYNC = 1;
  localparam int unsigned B_DSYNC = 2;
  localparam int unsigned B_IRQ   = 3;
  localparam int unsigned B_ONE   = 4;
  localparam int unsigned B_SINC  = 5;
  localparam int unsigned B_SDEC  = 6;
  localparam int unsigned B_SMEM  = 7;
  localparam int unsigned B_DINC  = 8;
  localparam int unsigned B_DDEC  = 9;
  localparam int unsigned B_DMEM  = 10;
  localparam int unsigned B_WORD  = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} xfer_st_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        sel_i,
  input  logic [AW-1:0]     wdata_i,
  input  logic              drq_i,
  input  logic              start_i,
  input  logic              step_i,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              en_o,
  output logic              elig_o,
  output logic              irq_o
);
  logic started_q;
  logic sync;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic inc,
                                        input logic dec, input logic word);
    logic [AW-1:0] stp;
    stp = word ? AW'(2) : AW'(1);
    if (inc && !dec)      nxt = a + stp;
    else if (dec && !inc) nxt = a - stp;
    else                  nxt = a;
  endfunction

  assign sync   = ctrl_o[B_SSYNC] | ctrl_o[B_DSYNC];
  assign elig_o = en_o && (cnt_o != '0) && (drq_i || (!sync && started_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o     <= '0;
      dst_o     <= '0;
      cnt_o     <= '0;
      ctrl_o    <= '0;
      en_o      <= 1'b0;
      started_q <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (wr_i) begin
        unique case (sel_i)
          SEL_SRC: src_o <= wdata_i;
          SEL_DST: dst_o <= wdata_i;
          SEL_CNT: cnt_o <= wdata_i[CW-1:0];
          SEL_CTRL: begin
            ctrl_o    <= wdata_i[CTRL_W-1:0];
            en_o      <= wdata_i[B_ONE] && !(wdata_i[B_SSYNC] && wdata_i[B_DSYNC])
                         && (cnt_o != '0);
            started_q <= 1'b0;
          end
          SEL_STOP: begin
            en_o      <= 1'b0;
            started_q <= 1'b0;
          end
          default: ;
        endcase
      end else begin
        if (start_i) started_q <= 1'b1;
        if (step_i) begin
          src_o <= nxt(src_o, ctrl_o[B_SINC], ctrl_o[B_SDEC], ctrl_o[B_WORD]);
          dst_o <= nxt(dst_o, ctrl_o[B_DINC], ctrl_o[B_DDEC], ctrl_o[B_WORD]);
          cnt_o <= cnt_o - 1'b1;
          if (cnt_o == CW'(1)) begin
            en_o      <= 1'b0;
            started_q <= 1'b0;
            irq_o     <= ctrl_o[B_IRQ];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] elig_i,
  input  logic [NCH-1:0] prio_i,
  input  logic           take_i,
  output logic           pick_o,
  output logic           any_o
);
  logic last_q;

  assign any_o = |elig_i;

  always_comb begin
    unique case (elig_i)
      2'b01:   pick_o = 1'b0;
      2'b10:   pick_o = 1'b1;
      2'b11: begin
        if (prio_i == 2'b01)      pick_o = 1'b0;
        else if (prio_i == 2'b10) pick_o = 1'b1;
        else                      pick_o = !last_q;
      end
      default: pick_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= 1'b1;
    else if (take_i) last_q <= pick_o;
  end
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           pick_i,
  input  logic           gnt_i,
  input  logic [NCH-1:0] abort_i,
  input  logic [DW-1:0]  rdata_i,
  output xfer_st_e       st_o,
  output logic           act_o,
  output logic           take_o,
  output logic           step_o,
  output logic [DW-1:0]  data_o
);
  logic kill;

  assign kill   = abort_i[act_o];
  assign take_o = (st_o == ST_IDLE) && req_i;
  assign step_o = (st_o == ST_WRITE) && gnt_i && !kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o   <= ST_IDLE;
      act_o  <= 1'b0;
      data_o <= '0;
    end else begin
      unique case (st_o)
        ST_IDLE: if (req_i) begin
          st_o  <= ST_READ;
          act_o <= pick_i;
        end
        ST_READ: begin
          if (kill) st_o <= ST_IDLE;
          else if (gnt_i) begin
            data_o <= rdata_i;
            st_o   <= ST_WRITE;
          end
        end
        ST_WRITE: if (kill || gnt_i) st_o <= ST_IDLE;
        default: st_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_two_ch.sv
module dma_two_ch
  import dma_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_ch_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic [1:0]    drq_i,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_en_o,
  output logic          bus_we_o,
  output logic          bus_mem_o,
  output logic          bus_word_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [1:0]    irq_o
);
  localparam int unsigned BW = 8;

  logic [AW-1:0]     src_w  [NCH];
  logic [AW-1:0]     dst_w  [NCH];
  logic [CW-1:0]     cnt_w  [NCH];
  logic [CTRL_W-1:0] ctrl_w [NCH];
  logic [NCH-1:0]    en_w, elig_w, prio_w, wr_w, start_w, step_w;
  logic              pick, any, take, step, act;
  logic [DW-1:0]     data;
  xfer_st_e          st;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign wr_w[c]    = reg_we_i && (reg_ch_i == c[0]);
    assign start_w[c] = take && (pick == c[0]);
    assign step_w[c]  = step && (act == c[0]);
    assign prio_w[c]  = ctrl_w[c][B_PRIO];

    dma_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_w[c]),
      .sel_i   (reg_sel_i),
      .wdata_i (reg_wdata_i),
      .drq_i   (drq_i[c]),
      .start_i (start_w[c]),
      .step_i  (step_w[c]),
      .src_o   (src_w[c]),
      .dst_o   (dst_w[c]),
      .cnt_o   (cnt_w[c]),
      .ctrl_o  (ctrl_w[c]),
      .en_o    (en_w[c]),
      .elig_o  (elig_w[c]),
      .irq_o   (irq_o[c])
    );
  end

  dma_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig_w),
    .prio_i (prio_w),
    .take_i (take),
    .pick_o (pick),
    .any_o  (any)
  );

  dma_mover #(.DW(DW)) u_mover (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (any),
    .pick_i  (pick),
    .gnt_i   (bus_gnt_i),
    .abort_i (wr_w),
    .rdata_i (bus_rdata_i),
    .st_o    (st),
    .act_o   (act),
    .take_o  (take),
    .step_o  (step),
    .data_o  (data)
  );

  assign bus_en_o    = (st != ST_IDLE);
  assign bus_we_o    = (st == ST_WRITE);
  assign bus_req_o   = bus_en_o || any;
  assign bus_word_o  = ctrl_w[act][B_WORD];
  assign bus_addr_o  = bus_we_o ? dst_w[act] : src_w[act];
  assign bus_mem_o   = bus_we_o ? ctrl_w[act][B_DMEM] : ctrl_w[act][B_SMEM];
  assign bus_wdata_o = bus_word_o ? data : {{(DW-BW){1'b0}}, data[BW-1:0]};

  always_comb begin
    unique case (reg_sel_i)
      SEL_SRC:  reg_rdata_o = src_w[reg_ch_i];
      SEL_DST:  reg_rdata_o = dst_w[reg_ch_i];
      SEL_CNT:  reg_rdata_o = AW'(cnt_w[reg_ch_i]);
      SEL_CTRL: reg_rdata_o = AW'({en_w[reg_ch_i], ctrl_w[reg_ch_i]});
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_two_ch_chk.sv
module dma_two_ch_chk #(
  parameter int unsigned AW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic          reg_ch_i,
  input logic [2:0]    reg_sel_i,
  input logic [AW-1:0] reg_wdata_i,
  input logic          bus_gnt_i,
  input logic          bus_en_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    irq_o,
  input logic [1:0]    en_w
);
  a_r10_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_o && !bus_gnt_i && !reg_we_i) |=> (bus_en_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  a_r3_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_o && !bus_we_o && bus_gnt_i && !reg_we_i) |=> (bus_en_o && bus_we_o));

  a_r6_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  a_r6_irq_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> $past(bus_en_o && bus_we_o && bus_gnt_i));

  a_r2_reject_both_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 3'd3 && reg_wdata_i[1] && reg_wdata_i[2]) |=> !en_w[$past(reg_ch_i)]);

  a_r9_stop_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 3'd4) |=> !en_w[$past(reg_ch_i)]);
endmodule

bind dma_two_ch dma_two_ch_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_ch_i    (reg_ch_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .bus_gnt_i   (bus_gnt_i),
  .bus_en_o    (bus_en_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .irq_o       (irq_o),
  .en_w        (en_w)
);

// File: tb/sim_dma_two_ch.sv
module sim_dma_two_ch;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_ch_i = 1'b0;
  logic [2:0]  reg_sel_i = 3'd0;
  logic [19:0] reg_wdata_i = '0;
  logic [19:0] reg_rdata_o;
  logic [1:0]  drq_i = 2'b00;
  logic        bus_req_o, bus_en_o, bus_we_o, bus_mem_o, bus_word_o;
  logic        bus_gnt_i = 1'b1;
  logic [19:0] bus_addr_o;
  logic [15:0] bus_wdata_o, bus_rdata_i;
  logic [1:0]  irq_o;

  int nchk = 0, nerr = 0;
  int gmode = 1;             // 0 random, 1 high, 2 low
  bit mon_on = 1'b1;
  logic [19:0] m_src, m_dst;
  logic [11:0] m_ctrl;
  logic [15:0] last_rd;
  int m_done = 0, irq_cnt = 0, ich = 0, nseq = 0;
  logic seq [8];
  int unsigned seed;

  always #10 clk_i = !clk_i;

  dma_two_ch u0 (.*);

  assign bus_rdata_i = bus_addr_o[15:0] ^ 16'h5A3C ^ {12'h0, bus_addr_o[19:16]};

  function automatic logic [19:0] stp(input logic [19:0] a, input logic inc, dec, word);
    logic [19:0] s = word ? 20'd2 : 20'd1;
    if (inc && !dec) return a + s;
    if (dec && !inc) return a - s;
    return a;
  endfunction

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #2;
    case (gmode)
      0: bus_gnt_i = ($urandom % 4) != 0;
      1: bus_gnt_i = 1'b1;
      default: bus_gnt_i = 1'b0;
    endcase
  end

  always @(negedge clk_i) begin
    if (irq_o[ich]) irq_cnt++;
    if (rst_ni && bus_en_o && bus_gnt_i) begin
      if (!mon_on) begin
        if (!bus_we_o && nseq < 8) begin seq[nseq] = bus_addr_o[12]; nseq++; end
      end else if (!bus_we_o) begin
        chk_eq("R3 read address", 32'(bus_addr_o), 32'(m_src));
        chk_eq("R5 source space", 32'(bus_mem_o), 32'(m_ctrl[7]));
        chk_eq("R4 width flag", 32'(bus_word_o), 32'(m_ctrl[11]));
        last_rd = bus_rdata_i;
      end else begin
        chk_eq("R3 write address", 32'(bus_addr_o), 32'(m_dst));
        chk_eq("R5 dest space", 32'(bus_mem_o), 32'(m_ctrl[10]));
        chk_eq("R3 write data", 32'(bus_wdata_o),
               32'(m_ctrl[11] ? last_rd : {8'h00, last_rd[7:0]}));
        m_src = stp(m_src, m_ctrl[5], m_ctrl[6], m_ctrl[11]);
        m_dst = stp(m_dst, m_ctrl[8], m_ctrl[9], m_ctrl[11]);
        m_done++;
      end
    end
  end

  task automatic wr(input int ch, input int sel, input logic [19:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_ch_i = ch[0]; reg_sel_i = sel[2:0]; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [19:0] v);
    @(negedge clk_i);
    reg_ch_i = ch[0]; reg_sel_i = sel[2:0];
    #1 v = reg_rdata_o;
  endtask

  task automatic wait_done(input int ch);
    logic [19:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(ch, 3, v);
      if (!v[12]) break;
    end
  endtask

  task automatic setup(input int ch, input logic [19:0] s, d, input int n, input logic [11:0] c);
    wr(ch, 0, s); wr(ch, 1, d); wr(ch, 2, 20'(n)); wr(ch, 3, {8'h0, c});
    m_src = s; m_dst = d; m_ctrl = c; m_done = 0; irq_cnt = 0; ich = ch;
  endtask

  initial begin
    #(20 * 150000);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [19:0] v;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++) begin
        rd(c, s, v); chk_eq("R1 register after reset", 32'(v), 0);
      end
    chk_eq("R1 bus idle", 32'({bus_req_o, bus_en_o, irq_o}), 0);

    // R2 rejected arming
    wr(0, 2, 20'd3);
    wr(0, 3, 20'h016);
    rd(0, 3, v); chk_eq("R2 both sync rejected", 32'(v[12]), 0);
    wr(0, 3, 20'h020);
    rd(0, 3, v); chk_eq("R2 bit4 clear rejected", 32'(v[12]), 0);
    wr(0, 2, 20'd0);
    wr(0, 3, 20'h030);
    rd(0, 3, v); chk_eq("R2 zero count rejected", 32'(v[12]), 0);
    drq_i = 2'b01;
    repeat (4) @(negedge clk_i);
    chk_eq("R2 no activity when not armed", 32'(bus_req_o), 0);
    drq_i = 2'b00;

    // R3 R7 armed but no request
    setup(0, 20'h00100, 20'h00200, 4, 12'h132);
    rd(0, 3, v); chk_eq("R2 armed status", 32'(v[12]), 1);
    repeat (6) @(negedge clk_i);
    chk_eq("R3 idle without request", 32'(bus_en_o), 0);
    // R7 synchronized single request -> one transfer
    drq_i = 2'b01; @(negedge clk_i); drq_i = 2'b00;
    repeat (8) @(negedge clk_i);
    rd(0, 2, v); chk_eq("R7 sync one transfer per request", 32'(v), 3);
    rd(0, 3, v); chk_eq("R7 still armed", 32'(v[12]), 1);
    wr(0, 4, 20'h0);

    // random runs: R4 R5 R6 R7 R10
    gmode = 0;
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom % 2;
      int n = 1 + ($urandom % 6);
      int sy = $urandom % 3;
      logic [11:0] c = 12'h010 | 12'($urandom & 32'hFE9);
      c[1] = (sy == 1); c[2] = (sy == 2);
      setup(ch, 20'($urandom), 20'($urandom), n, c);
      rd(ch, 3, v); chk_eq("R2 arm valid word", 32'(v[12]), 1);
      drq_i[ch] = 1'b1;
      if (sy == 0) begin @(negedge clk_i); drq_i[ch] = 1'b0; end
      wait_done(ch);
      drq_i = 2'b00;
      repeat (2) @(negedge clk_i);
      chk_eq("R6 transfers equal count", 32'(m_done), 32'(n));
      rd(ch, 2, v); chk_eq("R6 count at zero", 32'(v), 0);
      rd(ch, 0, v); chk_eq("R4 final source", 32'(v), 32'(m_src));
      rd(ch, 1, v); chk_eq("R4 final destination", 32'(v), 32'(m_dst));
      chk_eq("R6 interrupt pulses", 32'(irq_cnt), 32'(c[3]));
    end

    // R4 wrap on decrement, word, destination hold
    gmode = 1;
    setup(1, 20'h00000, 20'h00ABC, 1, 12'hB50);
    drq_i = 2'b10; @(negedge clk_i); drq_i = 2'b00;
    wait_done(1);
    rd(1, 0, v); chk_eq("R4 decrement wraps", 32'(v), 32'h0FFFFE);
    rd(1, 1, v); chk_eq("R4 both bits hold", 32'(v), 32'h00ABC);

    // R8 priority and alternation
    mon_on = 1'b0;
    wr(0, 0, 20'h00000); wr(0, 2, 20'd2); wr(0, 3, 20'h130);
    wr(1, 0, 20'h01000); wr(1, 2, 20'd2); wr(1, 3, 20'h131);
    nseq = 0; drq_i = 2'b11;
    repeat (20) @(negedge clk_i);
    drq_i = 2'b00;
    chk_eq("R8 priority order", 32'({seq[0], seq[1], seq[2], seq[3]}), 32'b1100);
    wr(0, 0, 20'h00000); wr(0, 2, 20'd2); wr(0, 3, 20'h130);
    wr(1, 0, 20'h01000); wr(1, 2, 20'd2); wr(1, 3, 20'h130);
    nseq = 0; drq_i = 2'b11;
    repeat (20) @(negedge clk_i);
    drq_i = 2'b00;
    chk_eq("R8 alternation", 32'({seq[0] ^ seq[1], seq[1] ^ seq[2], seq[2] ^ seq[3]}), 32'b111);
    mon_on = 1'b1;

    // R9 R10 stop while stalled, then resume
    setup(0, 20'h00100, 20'h00200, 5, 12'h1B0);
    gmode = 2;
    repeat (2) @(negedge clk_i);
    drq_i = 2'b01; @(negedge clk_i); drq_i = 2'b00;
    repeat (4) @(negedge clk_i);
    chk_eq("R10 stalled read pending", 32'({bus_en_o, bus_we_o}), 32'b10);
    chk_eq("R10 nothing completed", 32'(m_done), 0);
    wr(0, 4, 20'h0);
    rd(0, 3, v); chk_eq("R9 stop disarms", 32'(v[12]), 0);
    chk_eq("R9 transfer abandoned", 32'(bus_en_o), 0);
    rd(0, 2, v); chk_eq("R9 count kept", 32'(v), 5);
    rd(0, 0, v); chk_eq("R9 source kept", 32'(v), 32'h00100);
    gmode = 1;
    wr(0, 3, 20'h1B0);
    drq_i = 2'b01; @(negedge clk_i); drq_i = 2'b00;
    wait_done(0);
    chk_eq("R9 resumed run length", 32'(m_done), 5);
    rd(0, 0, v); chk_eq("R9 resumed source", 32'(v), 32'h00105);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule